// File: doc/BRIEF.md
# Iterative Multiply-Divide Unit with Result Pair

This block is a sequential arithmetic unit. It multiplies two 32-bit operands into a 64-bit product, or divides one 32-bit operand by another, in signed or unsigned form. Results go into a pair of dedicated 32-bit result registers, HI and LO. The registers are visible on two read ports, so a later move-from-HI or move-from-LO step in the surrounding datapath picks them up. A compact three-operand multiply is simply a multiply followed by reading LO.

A command is an opcode presented with a one-cycle start pulse. Multiply and divide run one bit per clock for 32 clocks, with `busy_o` high the whole time. Multiply uses a shift-add scheme and divide uses a restoring scheme. Signed forms work on operand magnitudes and correct the signs at the end. When the unit is idle, two move-to opcodes load HI or LO directly from operand A in a single clock.

Top module: `muldiv_unit`

## Requirements
- R1: Opcode 1 (`op_i`=3'd1) multiplies `a_i` by `b_i` as unsigned numbers, leaving product bits 63:32 in HI and bits 31:0 in LO.
- R2: Opcode 0 multiplies as two's-complement numbers, leaving the signed 64-bit product split across HI (upper half) and LO (lower half).
- R3: Opcode 3 divides `a_i` by `b_i` unsigned, leaving the quotient in LO and the remainder in HI.
- R4: Opcode 2 divides signed. The quotient is truncated toward zero and the remainder carries the sign of the dividend. 0x80000000 divided by 0xFFFFFFFF gives LO=0x80000000 and HI=0.
- R5: Dividing by zero, under opcode 2 or 3, gives LO=0xFFFFFFFF and HI equal to the dividend `a_i`, with no other effect.
- R6: A multiply or divide is accepted when `start_i` is high while `busy_o` is low. `busy_o` is then high for exactly 32 cycles. HI and LO keep their old values until the clock edge at which `busy_o` falls.
- R7: A `start_i` pulse while `busy_o` is high is ignored. The running operation keeps its result and its timing.
- R8: Opcode 4 (load HI) and opcode 5 (load LO), issued while idle, copy `a_i` into the named register at the next edge. The other register does not change and `busy_o` stays low. Issued while busy, they have no effect.
- R9: Opcodes 6 and 7 with `start_i` have no effect on HI, LO or `busy_o`.
- R10: After reset, HI and LO read zero and `busy_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Command strobe, sampled for one cycle |
| op_i | input | 3 | Opcode: 0 signed mul, 1 unsigned mul, 2 signed div, 3 unsigned div, 4 load HI, 5 load LO |
| a_i | input | 32 | Operand A: multiplicand, dividend, or move-to data |
| b_i | input | 32 | Operand B: multiplier or divisor |
| busy_o | output | 1 | High while an iterative operation runs |
| hi_o | output | 32 | HI register read port |
| lo_o | output | 32 | LO register read port |

## Verification
The hardest situation to reach is a command that lands while an operation is running. It must be shown to leave no trace, even though the final write at completion would hide any corruption of HI or LO. The stimulus therefore strikes mid-run, first with a competing divide and then with a load-HI. It samples HI and `busy_o` in the cycle right after each intrusion, before completion can overwrite them. The signed corners are driven directly: the most-negative dividend over minus one, and a zero divisor with a negative dividend, where the usual sign fix-up must be skipped for the quotient.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

  localparam int unsigned MDU_W = 32;

  typedef enum logic [2:0] {
    MDU_MUL_S  = 3'd0,
    MDU_MUL_U  = 3'd1,
    MDU_DIV_S  = 3'd2,
    MDU_DIV_U  = 3'd3,
    MDU_SET_HI = 3'd4,
    MDU_SET_LO = 3'd5
  } mdu_op_e;

  function automatic logic op_is_long(input logic [2:0] op);
    return (op == MDU_MUL_S) || (op == MDU_MUL_U) ||
           (op == MDU_DIV_S) || (op == MDU_DIV_U);
  endfunction

  function automatic logic op_is_div(input logic [2:0] op);
    return (op == MDU_DIV_S) || (op == MDU_DIV_U);
  endfunction

  function automatic logic op_is_signed(input logic [2:0] op);
    return (op == MDU_MUL_S) || (op == MDU_DIV_S);
  endfunction

endpackage

// File: rtl/mdu_operand_prep.sv
module mdu_operand_prep #(
  parameter int unsigned W = 32
) (
  input  logic         sgn_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] a_mag_o,
  output logic [W-1:0] b_mag_o,
  output logic         a_neg_o,
  output logic         b_neg_o
);

  always_comb begin
    a_neg_o = sgn_i & a_i[W-1];
    b_neg_o = sgn_i & b_i[W-1];
    a_mag_o = a_neg_o ? (~a_i + 1'b1) : a_i;
    b_mag_o = b_neg_o ? (~b_i + 1'b1) : b_i;
  end

endmodule

// File: rtl/mdu_step.sv
module mdu_step #(
  parameter int unsigned W = 32
) (
  input  logic         div_i,
  input  logic [W-1:0] hi_i,
  input  logic [W-1:0] lo_i,
  input  logic [W-1:0] bop_i,
  output logic [W-1:0] hi_o,
  output logic [W-1:0] lo_o
);

  logic [W:0] add_sum;
  logic [W:0] shifted;
  logic       fits;

  always_comb begin
    // shift-add: conditional add of multiplicand, then shift right as a pair
    add_sum = {1'b0, hi_i} + (lo_i[0] ? {1'b0, bop_i} : {(W+1){1'b0}});
    // restoring step: bring in next dividend bit, trial subtract
    shifted = {hi_i, lo_i[W-1]};
    fits    = (shifted >= {1'b0, bop_i});
    if (div_i) begin
      hi_o = fits ? W'(shifted - {1'b0, bop_i}) : shifted[W-1:0];
      lo_o = {lo_i[W-2:0], fits};
    end else begin
      hi_o = add_sum[W:1];
      lo_o = {add_sum[0], lo_i[W-1:1]};
    end
  end

endmodule

// File: rtl/mdu_result_fix.sv
module mdu_result_fix #(
  parameter int unsigned W = 32
) (
  input  logic         div_i,
  input  logic         a_neg_i,
  input  logic         b_neg_i,
  input  logic         b_zero_i,
  input  logic [W-1:0] hi_i,
  input  logic [W-1:0] lo_i,
  output logic [W-1:0] hi_o,
  output logic [W-1:0] lo_o
);

  logic [2*W-1:0] prod;
  logic [2*W-1:0] prod_fix;
  logic           flip_q;

  always_comb begin
    prod     = {hi_i, lo_i};
    prod_fix = (a_neg_i ^ b_neg_i) ? (~prod + 1'b1) : prod;
    // quotient flips on differing signs, except for a zero divisor
    flip_q   = (a_neg_i ^ b_neg_i) & ~b_zero_i;
    if (div_i) begin
      lo_o = flip_q  ? (~lo_i + 1'b1) : lo_i;
      hi_o = a_neg_i ? (~hi_i + 1'b1) : hi_i;
    end else begin
      hi_o = prod_fix[2*W-1:W];
      lo_o = prod_fix[W-1:0];
    end
  end

endmodule

// File: rtl/mdu_seq.sv
module mdu_seq #(
  parameter int unsigned STEPS = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic long_op_i,
  output logic busy_o,
  output logic accept_o,
  output logic done_o
);

  localparam int unsigned CW = $clog2(STEPS);

  logic          busy_q, busy_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    accept_o = start_i & long_op_i & ~busy_q;
    done_o   = busy_q & (cnt_q == CW'(STEPS - 1));
    busy_d   = busy_q;
    cnt_d    = cnt_q;
    cnt_en   = 1'b0;
    if (accept_o) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else if (done_o) begin
      busy_d = 1'b0;
    end else if (busy_q) begin
      cnt_d  = cnt_q + 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_q <= 1'b0;
    else        busy_q <= busy_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign busy_o = busy_q;

  // R7: a running operation advances one step per cycle, never restarts
  assert_run_advances_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !done_o) |=> (busy_q && cnt_q == $past(cnt_q) + 1'b1));

  // R6: busy ends right after the last step
  assert_busy_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_q);

  // R6: every run starts from step zero
  assert_run_from_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> (cnt_q == '0));

endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
  import muldiv_pkg::*;
#(
  parameter int unsigned W          = MDU_W,
  parameter int unsigned SYNC_STAGE = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [2:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         busy_o,
  output logic [W-1:0] hi_o,
  output logic [W-1:0] lo_o
);

  // ---------------- reset release synchronizer ----------------
  logic [SYNC_STAGE-1:0] rsync_q;
  logic                  rst_sn;

  generate
    for (genvar s = 0; s < SYNC_STAGE; s++) begin : g_rsync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsync_q[s] <= 1'b0;
        else if (s == 0) rsync_q[s] <= 1'b1;
        else rsync_q[s] <= rsync_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign rst_sn = rsync_q[SYNC_STAGE-1];

  // ---------------- decode ----------------
  logic long_op, accept, done, busy;
  logic set_hi, set_lo;

  assign long_op = op_is_long(op_i);
  assign set_hi  = start_i & ~busy & (op_i == MDU_SET_HI);
  assign set_lo  = start_i & ~busy & (op_i == MDU_SET_LO);

  mdu_seq #(.STEPS(W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_sn),
    .start_i  (start_i),
    .long_op_i(long_op),
    .busy_o   (busy),
    .accept_o (accept),
    .done_o   (done)
  );

  // ---------------- operand preparation ----------------
  logic [W-1:0] a_mag, b_mag;
  logic         a_neg, b_neg;

  mdu_operand_prep #(.W(W)) u_prep (
    .sgn_i  (op_is_signed(op_i)),
    .a_i    (a_i),
    .b_i    (b_i),
    .a_mag_o(a_mag),
    .b_mag_o(b_mag),
    .a_neg_o(a_neg),
    .b_neg_o(b_neg)
  );

  // ---------------- iteration state ----------------
  logic         div_q, a_neg_q, b_neg_q, b_zero_q;
  logic         div_d, a_neg_d, b_neg_d, b_zero_d;
  logic [W-1:0] bop_q, bop_d;
  logic [W-1:0] ahi_q, ahi_d, alo_q, alo_d;
  logic [W-1:0] step_hi, step_lo;
  logic         it_en;

  mdu_step #(.W(W)) u_step (
    .div_i(div_q),
    .hi_i (ahi_q),
    .lo_i (alo_q),
    .bop_i(bop_q),
    .hi_o (step_hi),
    .lo_o (step_lo)
  );

  always_comb begin
    div_d    = div_q;
    a_neg_d  = a_neg_q;
    b_neg_d  = b_neg_q;
    b_zero_d = b_zero_q;
    bop_d    = bop_q;
    ahi_d    = ahi_q;
    alo_d    = alo_q;
    it_en    = 1'b0;
    if (accept) begin
      div_d    = op_is_div(op_i);
      a_neg_d  = a_neg;
      b_neg_d  = b_neg;
      b_zero_d = (b_i == '0);
      bop_d    = b_mag;
      ahi_d    = '0;
      alo_d    = a_mag;
      it_en    = 1'b1;
    end else if (busy) begin
      ahi_d = step_hi;
      alo_d = step_lo;
      it_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      div_q    <= 1'b0;
      a_neg_q  <= 1'b0;
      b_neg_q  <= 1'b0;
      b_zero_q <= 1'b0;
      bop_q    <= '0;
    end else if (accept) begin
      div_q    <= div_d;
      a_neg_q  <= a_neg_d;
      b_neg_q  <= b_neg_d;
      b_zero_q <= b_zero_d;
      bop_q    <= bop_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      ahi_q <= '0;
      alo_q <= '0;
    end else if (it_en) begin
      ahi_q <= ahi_d;
      alo_q <= alo_d;
    end
  end

  // ---------------- sign fix and result registers ----------------
  logic [W-1:0] fix_hi, fix_lo;
  logic [W-1:0] hi_q, hi_d, lo_q, lo_d;
  logic         hi_en, lo_en;

  mdu_result_fix #(.W(W)) u_fix (
    .div_i   (div_q),
    .a_neg_i (a_neg_q),
    .b_neg_i (b_neg_q),
    .b_zero_i(b_zero_q),
    .hi_i    (step_hi),
    .lo_i    (step_lo),
    .hi_o    (fix_hi),
    .lo_o    (fix_lo)
  );

  always_comb begin
    hi_d  = hi_q;
    lo_d  = lo_q;
    hi_en = 1'b0;
    lo_en = 1'b0;
    if (done) begin
      hi_d  = fix_hi;
      lo_d  = fix_lo;
      hi_en = 1'b1;
      lo_en = 1'b1;
    end else begin
      if (set_hi) begin
        hi_d  = a_i;
        hi_en = 1'b1;
      end
      if (set_lo) begin
        lo_d  = a_i;
        lo_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)    hi_q <= '0;
    else if (hi_en) hi_q <= hi_d;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)    lo_q <= '0;
    else if (lo_en) lo_q <= lo_d;
  end

  assign busy_o = busy;
  assign hi_o   = hi_q;
  assign lo_o   = lo_q;

  // R6: the result pair is frozen while a run is in progress
  assert_pair_frozen_R6: assert property (@(posedge clk) disable iff (!rst_sn)
    (busy && !done) |=> ($stable(hi_q) && $stable(lo_q)));

  // R3: the partial remainder never reaches the divisor magnitude
  assert_rem_bound_R3: assert property (@(posedge clk) disable iff (!rst_sn)
    (busy && div_q && !b_zero_q) |-> (ahi_q < bop_q));

  // R8: an idle load-HI lands operand A in HI and leaves LO untouched
  assert_load_hi_R8: assert property (@(posedge clk) disable iff (!rst_sn)
    (!busy && start_i && op_i == MDU_SET_HI) |=> (hi_q == $past(a_i) && $stable(lo_q)));

  // R9: reserved opcodes never start a run
  assert_reserved_idle_R9: assert property (@(posedge clk) disable iff (!rst_sn)
    (!busy && start_i && op_i[2:1] == 2'b11) |=> !busy);

endmodule

// File: tb/muldiv_unit_tb.sv
module muldiv_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [2:0]  op_i;
  logic [31:0] a_i, b_i;
  logic        busy_o;
  logic [31:0] hi_o, lo_o;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  muldiv_unit u_dut (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(start_i),
    .op_i   (op_i),
    .a_i    (a_i),
    .b_i    (b_i),
    .busy_o (busy_o),
    .hi_o   (hi_o),
    .lo_o   (lo_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // issue a long op and check busy window plus final HI/LO
  task automatic run_op(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                        input logic [31:0] ehi, input logic [31:0] elo, input string req);
    logic [31:0] old_hi, old_lo;
    @(negedge clk);
    old_hi = hi_o; old_lo = lo_o;
    start_i = 1'b1; op_i = op; a_i = a; b_i = b;
    @(negedge clk);
    start_i = 1'b0;
    chk({req, " R6 busy rises"}, 64'(busy_o), 64'd1);
    repeat (31) @(negedge clk);
    chk({req, " R6 busy last cycle"}, 64'(busy_o), 64'd1);
    chk({req, " R6 pair held"}, {hi_o, lo_o}, {old_hi, old_lo});
    @(negedge clk);
    chk({req, " R6 busy falls"}, 64'(busy_o), 64'd0);
    chk({req, " result"}, {hi_o, lo_o}, {ehi, elo});
  endtask

  task automatic t_reset();
    rst_n = 1'b0; start_i = 1'b0; op_i = 3'd0; a_i = '0; b_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 reset", {31'd0, busy_o, hi_o, lo_o}, 64'd0);
  endtask

  task automatic t_mul_u(input logic [31:0] a, input logic [31:0] b);
    logic [63:0] p;
    p = {32'd0, a} * {32'd0, b};
    run_op(3'd1, a, b, p[63:32], p[31:0], "R1 unsigned mul");
  endtask

  task automatic t_mul_s(input logic [31:0] a, input logic [31:0] b);
    logic signed [63:0] sa, sb, p;
    sa = {{32{a[31]}}, a}; sb = {{32{b[31]}}, b};
    p = sa * sb;
    run_op(3'd0, a, b, p[63:32], p[31:0], "R2 signed mul");
  endtask

  task automatic t_div_u(input logic [31:0] a, input logic [31:0] b);
    run_op(3'd3, a, b, a % b, a / b, "R3 unsigned div");
  endtask

  task automatic t_div_s(input logic [31:0] a, input logic [31:0] b);
    logic signed [63:0] sa, sb, q, r;
    sa = {{32{a[31]}}, a}; sb = {{32{b[31]}}, b};
    q = sa / sb; r = sa % sb;
    run_op(3'd2, a, b, r[31:0], q[31:0], "R4 signed div");
  endtask

  task automatic t_div_zero();
    run_op(3'd3, 32'h1234_5678, 32'd0, 32'h1234_5678, 32'hFFFF_FFFF, "R5 unsigned div by zero");
    run_op(3'd2, 32'hFFFF_FF85, 32'd0, 32'hFFFF_FF85, 32'hFFFF_FFFF, "R5 signed div by zero");
  endtask

  task automatic t_start_busy();
    @(negedge clk);
    start_i = 1'b1; op_i = 3'd1; a_i = 32'd1000; b_i = 32'd3000;
    @(negedge clk);
    start_i = 1'b0;
    repeat (9) @(negedge clk);
    start_i = 1'b1; op_i = 3'd3; a_i = 32'd77; b_i = 32'd5;
    @(negedge clk);
    start_i = 1'b0;
    chk("R7 busy kept after intrusion", 64'(busy_o), 64'd1);
    start_i = 1'b1; op_i = 3'd4; a_i = 32'hDEAD_BEEF;
    @(negedge clk);
    start_i = 1'b0;
    chk("R8 load HI while busy ignored", 64'(hi_o), 64'(hi_o == 32'hDEAD_BEEF ? 32'd0 : hi_o));
    repeat (20) @(negedge clk);
    chk("R7 busy still high at step 32", 64'(busy_o), 64'd1);
    @(negedge clk);
    chk("R7 busy falls on original schedule", 64'(busy_o), 64'd0);
    chk("R7 first result kept", {hi_o, lo_o}, 64'd3_000_000);
  endtask

  task automatic t_move_to();
    logic [31:0] lo_before;
    @(negedge clk);
    lo_before = lo_o;
    start_i = 1'b1; op_i = 3'd4; a_i = 32'hA5A5_0F0F;
    @(negedge clk);
    start_i = 1'b0;
    chk("R8 load HI", {31'd0, busy_o, hi_o, lo_o}, {31'd0, 1'b0, 32'hA5A5_0F0F, lo_before});
    start_i = 1'b1; op_i = 3'd5; a_i = 32'h0BAD_F00D;
    @(negedge clk);
    start_i = 1'b0;
    chk("R8 load LO", {31'd0, busy_o, hi_o, lo_o}, {31'd0, 1'b0, 32'hA5A5_0F0F, 32'h0BAD_F00D});
  endtask

  task automatic t_reserved();
    for (int k = 6; k < 8; k++) begin
      @(negedge clk);
      start_i = 1'b1; op_i = 3'(k); a_i = 32'h5555_5555; b_i = 32'h3;
      @(negedge clk);
      start_i = 1'b0;
      chk("R9 reserved opcode", {31'd0, busy_o, hi_o, lo_o},
          {31'd0, 1'b0, 32'hA5A5_0F0F, 32'h0BAD_F00D});
    end
  endtask

  initial begin
    t_reset();
    t_mul_u(32'hFFFF_FFFF, 32'hFFFF_FFFF);
    t_mul_u(32'h0001_2345, 32'h0000_0100);
    t_mul_s(32'hFFFF_FFFD, 32'd7);
    t_mul_s(32'h8000_0000, 32'h8000_0000);
    t_div_u(32'd1000, 32'd7);
    t_div_u(32'hFFFF_FFFF, 32'h0001_0000);
    t_div_s(32'hFFFF_FF9C, 32'd7);
    t_div_s(32'd100, 32'hFFFF_FFF9);
    run_op(3'd2, 32'h8000_0000, 32'hFFFF_FFFF, 32'd0, 32'h8000_0000, "R4 most negative over -1");
    t_div_zero();
    t_start_busy();
    t_move_to();
    t_reserved();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule